// File: doc/BRIEF.md
# Filtered Bandwidth Usage Monitor

This block counts the bytes moved by memory transactions. Every transaction carries a valid strobe, a security flag, a partition ID, a monitoring-group tag and a byte count. The block holds two independent register banks, one for the Secure state and one for the Non-secure state. Each bank sees only the traffic of its own state. It adds the byte count of each accepted transaction to a 32-bit counter. A bank can limit counting to one partition, to one group, or to both.

Each bank can copy its counter into a capture register when a chosen event occurs. The event is one of six external pulses or a software capture strobe aimed at that bank's security state. The counter can optionally be cleared at the moment of capture. A carry out of the counter sets a sticky status bit, and the counter either wraps or freezes after it. While the status bit is set and the interrupt enable is on, the bank drives an interrupt output.

Software reaches all registers over a simple bus. Writes take effect in one cycle and reads are combinational. Address bit 2 selects the bank (1 = Secure). Bits [1:0] select the register: 0 control, 1 filter, 2 count, 3 capture.

Top module: `bw_usage_monitor`

## Requirements
- R1: While control bit 31 (enable) is 0, a bank's counter and capture register do not change, except through a software write to the count register.
- R2: A transaction with txn_secure=1 is seen only by the Secure bank, and one with txn_secure=0 only by the Non-secure bank. Each accepted transaction adds txn_bytes to that bank's counter, and the new value is readable in the cycle after the strobe.
- R3: Control bit 16 restricts counting to txn_part equal to filter bits [15:0]. Control bit 17 restricts counting to txn_grp equal to filter bits [23:16]. A bit at 0 accepts any value of its tag.
- R4: Control bits [30:28] select the capture trigger: 0 none, 1..6 ext_capt[0..5], 7 sw_capt when sw_capt_secure equals the bank's state. An unimplemented source never fires, and any other event is ignored.
- R5: A capture stores the counter value from before that cycle's increment. If control bit 27 is set, the counter is then loaded with that cycle's increment, which is 0 when there is no traffic.
- R6: A carry out of bit 31 leaves the counter holding the wrapped sum and sets control bit 26. Bit 26 stays set until software writes it to 0.
- R7: With control bit 24 set, once bit 26 is set the counter ignores all traffic until bit 26 is cleared.
- R8: ovf_irq[b] is high while bank b has both control bit 26 and control bit 25 set. Index 0 is Non-secure and index 1 is Secure.
- R9: Control bits [23:18] and [15:8] read as 0. Bits [7:0] read as 0x42. After reset every register reads 0 except that type code.
- R10: A software write to the count register in the same cycle as an increment loads exactly the written value.
- R11: Writes to the capture register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | [2] bank (1 = Secure), [1:0] register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| txn_valid | input | 1 | Transaction strobe |
| txn_secure | input | 1 | Transaction security state |
| txn_part | input | 16 | Transaction partition ID |
| txn_grp | input | 8 | Transaction monitoring group |
| txn_bytes | input | 16 | Bytes carried by the transaction |
| ext_capt | input | 6 | External capture event pulses 1..6 |
| sw_capt | input | 1 | Software capture-write strobe |
| sw_capt_secure | input | 1 | Security state targeted by sw_capt |
| ovf_irq | output | 2 | Overflow interrupt per bank |

## Verification
A table of transactions is run with the Non-secure bank filtering on partition and the Secure bank filtering on group. The table mixes hits, partition misses, group misses and traffic from the wrong state, so that each match term and the bank steering are exposed on their own. Capture is driven by the selected pulse and by a wrong pulse, and by a software strobe aimed at each state. Each capture is also placed in the same cycle as an increment, which separates the pre-increment capture value from the post-increment one. Near-full counter values show wrap and freeze, the sticky status and the interrupt. A same-cycle count write shows that software wins over traffic.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  localparam int REG_W = 32;
  localparam logic [7:0] MON_TYPE = 8'h42;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_FILT  = 2'd1,
    REG_COUNT = 2'd2,
    REG_CAPT  = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic       en;
    logic [2:0] capt_sel;
    logic       capt_rst;
    logic       ovf_sts;
    logic       ovf_irq_en;
    logic       ovf_frz;
    logic       match_grp;
    logic       match_part;
  } ctrl_t;

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    return {c.en, c.capt_sel, c.capt_rst, c.ovf_sts, c.ovf_irq_en, c.ovf_frz,
            6'd0, c.match_grp, c.match_part, 8'd0, MON_TYPE};
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.en         = w[31];
    c.capt_sel   = w[30:28];
    c.capt_rst   = w[27];
    c.ovf_sts    = w[26];
    c.ovf_irq_en = w[25];
    c.ovf_frz    = w[24];
    c.match_grp  = w[17];
    c.match_part = w[16];
    return c;
  endfunction
endpackage

// File: rtl/bwmon_filter.sv
module bwmon_filter #(
  parameter bit SECURE = 1'b0,
  parameter int PART_W = 16,
  parameter int GRP_W  = 8
) (
  input  logic              txn_valid,
  input  logic              txn_secure,
  input  logic [PART_W-1:0] txn_part,
  input  logic [GRP_W-1:0]  txn_grp,
  input  logic [PART_W-1:0] flt_part,
  input  logic [GRP_W-1:0]  flt_grp,
  input  logic              match_part,
  input  logic              match_grp,
  output logic              hit
);
  logic part_ok, grp_ok;
  assign part_ok = !match_part || (txn_part == flt_part);
  assign grp_ok  = !match_grp  || (txn_grp == flt_grp);
  assign hit     = txn_valid && (txn_secure == SECURE) && part_ok && grp_ok;
endmodule

// File: rtl/bwmon_capt_sel.sv
module bwmon_capt_sel #(
  parameter bit         SECURE   = 1'b0,
  parameter int         N_EXT    = 6,
  parameter logic [5:0] EXT_IMPL = 6'h3F
) (
  input  logic [2:0]       sel,
  input  logic [N_EXT-1:0] ext_evt,
  input  logic             sw_strobe,
  input  logic             sw_secure,
  output logic             fire
);
  logic [7:0] code_hit;
  assign code_hit[0] = 1'b0;
  for (genvar gi = 1; gi <= 6; gi++) begin : g_code
    if (gi <= N_EXT && EXT_IMPL[gi-1]) begin : g_on
      assign code_hit[gi] = ext_evt[gi-1];
    end else begin : g_off
      assign code_hit[gi] = 1'b0;
    end
  end
  assign code_hit[7] = sw_strobe && (sw_secure == SECURE);
  assign fire = code_hit[sel];
endmodule

// File: rtl/bwmon_bank.sv
module bwmon_bank
  import bwmon_pkg::*;
#(
  parameter bit         SECURE   = 1'b0,
  parameter int         PART_W   = 16,
  parameter int         GRP_W    = 8,
  parameter int         BYTES_W  = 16,
  parameter int         N_EXT    = 6,
  parameter logic [5:0] EXT_IMPL = 6'h3F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_idx,
  input  logic [REG_W-1:0]   wdata,
  input  logic [1:0]         rd_idx,
  output logic [REG_W-1:0]   rdata,
  input  logic               txn_valid,
  input  logic               txn_secure,
  input  logic [PART_W-1:0]  txn_part,
  input  logic [GRP_W-1:0]   txn_grp,
  input  logic [BYTES_W-1:0] txn_bytes,
  input  logic [N_EXT-1:0]   ext_evt,
  input  logic               sw_capt,
  input  logic               sw_capt_secure,
  output logic               irq
);
  localparam int FILT_PAD = REG_W - PART_W - GRP_W;

  function automatic logic [REG_W:0] add_wide(input logic [REG_W-1:0] a,
                                              input logic [REG_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  ctrl_t             ctrl_q;
  logic [PART_W-1:0] flt_part_q;
  logic [GRP_W-1:0]  flt_grp_q;
  logic [REG_W-1:0]  cnt_q, capt_q;

  // named internal events
  logic             ctrl_wr, filt_wr, cnt_wr;
  logic             hit, sel_fire, capt_fire, frozen, counting, ovf_set;
  logic [REG_W-1:0] inc_amt;
  logic [REG_W:0]   sum;

  assign ctrl_wr = wr_en && (wr_idx == REG_CTRL);
  assign filt_wr = wr_en && (wr_idx == REG_FILT);
  assign cnt_wr  = wr_en && (wr_idx == REG_COUNT);

  bwmon_filter #(.SECURE(SECURE), .PART_W(PART_W), .GRP_W(GRP_W)) u_filter (
    .txn_valid(txn_valid), .txn_secure(txn_secure), .txn_part(txn_part),
    .txn_grp(txn_grp), .flt_part(flt_part_q), .flt_grp(flt_grp_q),
    .match_part(ctrl_q.match_part), .match_grp(ctrl_q.match_grp), .hit(hit)
  );

  bwmon_capt_sel #(.SECURE(SECURE), .N_EXT(N_EXT), .EXT_IMPL(EXT_IMPL)) u_capt (
    .sel(ctrl_q.capt_sel), .ext_evt(ext_evt), .sw_strobe(sw_capt),
    .sw_secure(sw_capt_secure), .fire(sel_fire)
  );

  assign frozen    = ctrl_q.ovf_frz && ctrl_q.ovf_sts;
  assign counting  = ctrl_q.en && hit && !frozen;
  assign inc_amt   = counting ? REG_W'(txn_bytes) : '0;
  assign sum       = add_wide(cnt_q, inc_amt);
  assign capt_fire = ctrl_q.en && sel_fire;
  assign ovf_set   = sum[REG_W] && !cnt_wr && !(capt_fire && ctrl_q.capt_rst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      flt_part_q <= '0;
      flt_grp_q  <= '0;
      cnt_q      <= '0;
      capt_q     <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_unpack(wdata);
      if (ovf_set) ctrl_q.ovf_sts <= 1'b1;
      if (filt_wr) begin
        flt_part_q <= wdata[PART_W-1:0];
        flt_grp_q  <= wdata[PART_W+GRP_W-1:PART_W];
      end
      if (capt_fire) capt_q <= cnt_q;
      if (cnt_wr)                             cnt_q <= wdata;
      else if (capt_fire && ctrl_q.capt_rst)  cnt_q <= inc_amt;
      else                                    cnt_q <= sum[REG_W-1:0];
    end
  end

  always_comb begin
    unique case (rd_idx)
      REG_CTRL:  rdata = ctrl_pack(ctrl_q);
      REG_FILT:  rdata = {{FILT_PAD{1'b0}}, flt_grp_q, flt_part_q};
      REG_COUNT: rdata = cnt_q;
      default:   rdata = capt_q;
    endcase
  end

  assign irq = ctrl_q.ovf_sts && ctrl_q.ovf_irq_en;

  p_disabled_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !cnt_wr) |=> (cnt_q == $past(cnt_q) && capt_q == $past(capt_q)));
  p_no_capt_sel0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.capt_sel == 3'd0) |-> !capt_fire);
  p_capt_pre_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capt_fire |=> capt_q == $past(cnt_q));
  p_capt_reset_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (capt_fire && ctrl_q.capt_rst && !cnt_wr) |=> cnt_q == $past(inc_amt));
  p_ovf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ctrl_q.ovf_sts);
  p_sticky_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ovf_sts && !ctrl_wr) |=> ctrl_q.ovf_sts);
  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !cnt_wr && !(capt_fire && ctrl_q.capt_rst)) |=> cnt_q == $past(cnt_q));
  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && ctrl_q.ovf_irq_en && !ctrl_wr) |=> irq);
  p_cnt_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(wdata));
  p_capt_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !capt_fire |=> capt_q == $past(capt_q));
endmodule

// File: rtl/bw_usage_monitor.sv
module bw_usage_monitor
  import bwmon_pkg::*;
#(
  parameter int         PART_W   = 16,
  parameter int         GRP_W    = 8,
  parameter int         BYTES_W  = 16,
  parameter int         N_EXT    = 6,
  parameter logic [5:0] EXT_IMPL = 6'h3F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               txn_valid,
  input  logic               txn_secure,
  input  logic [PART_W-1:0]  txn_part,
  input  logic [GRP_W-1:0]   txn_grp,
  input  logic [BYTES_W-1:0] txn_bytes,
  input  logic [N_EXT-1:0]   ext_capt,
  input  logic               sw_capt,
  input  logic               sw_capt_secure,
  output logic [1:0]         ovf_irq
);
  localparam int N_BANK = 2;

  logic [REG_W-1:0] bank_rdata [N_BANK];

  for (genvar gb = 0; gb < N_BANK; gb++) begin : g_bank
    bwmon_bank #(
      .SECURE(gb == 1), .PART_W(PART_W), .GRP_W(GRP_W), .BYTES_W(BYTES_W),
      .N_EXT(N_EXT), .EXT_IMPL(EXT_IMPL)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && (reg_addr[2] == 1'(gb))),
      .wr_idx(reg_addr[1:0]), .wdata(reg_wdata),
      .rd_idx(reg_addr[1:0]), .rdata(bank_rdata[gb]),
      .txn_valid(txn_valid), .txn_secure(txn_secure), .txn_part(txn_part),
      .txn_grp(txn_grp), .txn_bytes(txn_bytes), .ext_evt(ext_capt),
      .sw_capt(sw_capt), .sw_capt_secure(sw_capt_secure), .irq(ovf_irq[gb])
    );
  end

  assign reg_rdata = bank_rdata[reg_addr[2]];

  p_ctrl_fixed_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] == 2'd0) |->
      (reg_rdata[23:18] == 6'd0 && reg_rdata[15:8] == 8'd0 && reg_rdata[7:0] == 8'h42));
endmodule

// File: tb/bw_usage_monitor_tb_top.sv
module bw_usage_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        txn_valid = 1'b0, txn_secure = 1'b0;
  logic [15:0] txn_part = '0;
  logic [7:0]  txn_grp = '0;
  logic [15:0] txn_bytes = '0;
  logic [5:0]  ext_capt = '0;
  logic        sw_capt = 1'b0, sw_capt_secure = 1'b0;
  logic [1:0]  ovf_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bw_usage_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_valid(txn_valid),
    .txn_secure(txn_secure), .txn_part(txn_part), .txn_grp(txn_grp),
    .txn_bytes(txn_bytes), .ext_capt(ext_capt), .sw_capt(sw_capt),
    .sw_capt_secure(sw_capt_secure), .ovf_irq(ovf_irq)
  );

  // addresses: [2] bank, [1:0] ctrl/filt/count/capt
  localparam logic [2:0] NS_CTRL = 3'd0, NS_FILT = 3'd1, NS_CNT = 3'd2, NS_CAPT = 3'd3;
  localparam logic [2:0] S_CTRL = 3'd4, S_FILT = 3'd5, S_CNT = 3'd6, S_CAPT = 3'd7;

  typedef struct packed {
    logic        sec;
    logic [15:0] part;
    logic [7:0]  grp;
    logic [15:0] bytes;
    logic        hit_ns;
    logic        hit_s;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 16'h0012, 8'h01, 16'd100,   1'b1, 1'b0},
    '{1'b0, 16'h0013, 8'h01, 16'd50,    1'b0, 1'b0},
    '{1'b1, 16'h0012, 8'h05, 16'd70,    1'b0, 1'b1},
    '{1'b1, 16'h0001, 8'h05, 16'd30,    1'b0, 1'b1},
    '{1'b1, 16'h0012, 8'h04, 16'd20,    1'b0, 1'b0},
    '{1'b0, 16'h0012, 8'hFF, 16'hFFFF,  1'b1, 1'b0},
    '{1'b0, 16'h0012, 8'h05, 16'd8,     1'b1, 1'b0},
    '{1'b1, 16'h7777, 8'h05, 16'd1,     1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic txn(input logic s, input logic [15:0] p, input logic [7:0] g,
                     input logic [15:0] b);
    @(negedge clk);
    txn_valid = 1'b1; txn_secure = s; txn_part = p; txn_grp = g; txn_bytes = b;
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] exp_ns, exp_s;
    exp_ns = 0; exp_s = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R9
    rd("R9 reset ns ctrl", NS_CTRL, 32'h0000_0042);
    rd("R9 reset s ctrl",  S_CTRL,  32'h0000_0042);
    rd("R9 reset ns count", NS_CNT, 32'h0);
    rd("R9 reset s capt", S_CAPT, 32'h0);
    chk("R8 reset irq", {30'd0, ovf_irq}, 32'h0);

    // R9 reserved bits: all-ones write; R8 irq with status and enable set
    wr(NS_CTRL, 32'hFFFF_FFFF);
    rd("R9 ctrl reserved", NS_CTRL, 32'hFF03_0042);
    chk("R8 irq ns", {31'd0, ovf_irq[0]}, 32'd1);
    wr(NS_CTRL, 32'h0);
    rd("R9 ctrl cleared", NS_CTRL, 32'h0000_0042);
    chk("R8 irq cleared", {31'd0, ovf_irq[0]}, 32'd0);

    // table run, R2 and R3: NS filters partition 0x12, S filters group 0x05
    wr(NS_FILT, 32'h0007_0012);
    wr(S_FILT,  32'h0005_9999);
    rd("R3 filter read", NS_FILT, 32'h0007_0012);
    wr(NS_CTRL, 32'h8001_0000);
    wr(S_CTRL,  32'h8002_0000);
    foreach (VECS[i]) begin
      txn(VECS[i].sec, VECS[i].part, VECS[i].grp, VECS[i].bytes);
      if (VECS[i].hit_ns) exp_ns += 32'(VECS[i].bytes);
      if (VECS[i].hit_s)  exp_s  += 32'(VECS[i].bytes);
      rd($sformatf("R2 R3 vec %0d ns count", i), NS_CNT, exp_ns);
      rd($sformatf("R2 R3 vec %0d s count", i),  S_CNT,  exp_s);
    end

    // R1: disabled bank ignores traffic and capture events
    wr(NS_CTRL, 32'h1000_0000);
    @(negedge clk);
    txn_valid = 1'b1; txn_secure = 1'b0; txn_part = 16'h0012; txn_bytes = 16'd500;
    ext_capt = 6'b000001;
    @(negedge clk);
    txn_valid = 1'b0; ext_capt = '0;
    rd("R1 count held", NS_CNT, exp_ns);
    rd("R1 capture held", NS_CAPT, 32'h0);

    // R10: count write beats same-cycle increment
    wr(NS_CTRL, 32'h8000_0000);
    @(negedge clk);
    reg_addr = NS_CNT; reg_wdata = 32'd1000; reg_wr = 1'b1;
    txn_valid = 1'b1; txn_secure = 1'b0; txn_bytes = 16'd5;
    @(negedge clk);
    reg_wr = 1'b0; txn_valid = 1'b0;
    rd("R10 write wins", NS_CNT, 32'd1000);

    // R4/R5: external event 3
    wr(NS_CTRL, 32'hB000_0000);
    @(negedge clk);
    ext_capt = 6'b000100; txn_valid = 1'b1; txn_secure = 1'b0; txn_bytes = 16'd10;
    @(negedge clk);
    ext_capt = '0; txn_valid = 1'b0;
    rd("R5 capture pre-increment", NS_CAPT, 32'd1000);
    rd("R5 count keeps running", NS_CNT, 32'd1010);
    @(negedge clk); ext_capt = 6'b000010;
    @(negedge clk); ext_capt = '0;
    rd("R4 wrong event ignored", NS_CAPT, 32'd1000);
    // R5 reset after capture with same-cycle traffic
    wr(NS_CTRL, 32'hB800_0000);
    @(negedge clk);
    ext_capt = 6'b000100; txn_valid = 1'b1; txn_bytes = 16'd7;
    @(negedge clk);
    ext_capt = '0; txn_valid = 1'b0;
    rd("R5 capture value", NS_CAPT, 32'd1010);
    rd("R5 count reloaded with increment", NS_CNT, 32'd7);
    // R4 software capture by security state
    wr(NS_CTRL, 32'hF800_0000);
    @(negedge clk); sw_capt = 1'b1; sw_capt_secure = 1'b1;
    @(negedge clk); sw_capt = 1'b0;
    rd("R4 sw other state ignored", NS_CAPT, 32'd1010);
    rd("R4 sw capture count", S_CAPT, 32'h0);
    @(negedge clk); sw_capt = 1'b1; sw_capt_secure = 1'b0;
    @(negedge clk); sw_capt = 1'b0;
    rd("R4 sw own state capture", NS_CAPT, 32'd7);
    rd("R5 count cleared", NS_CNT, 32'd0);
    wr(NS_CTRL, 32'h8000_0000);
    @(negedge clk); ext_capt = 6'h3F; sw_capt = 1'b1;
    @(negedge clk); ext_capt = '0; sw_capt = 1'b0;
    rd("R4 select 0 no capture", NS_CAPT, 32'd7);

    // R6 wrap and sticky status, R8 irq
    wr(NS_CTRL, 32'h8200_0000);
    wr(NS_CNT, 32'hFFFF_FFF0);
    txn(1'b0, 16'h0, 8'h0, 16'h0020);
    rd("R6 wrapped count", NS_CNT, 32'h0000_0010);
    rd("R6 status set", NS_CTRL, 32'h8600_0042);
    chk("R8 irq raised", {30'd0, ovf_irq}, 32'h1);
    txn(1'b0, 16'h0, 8'h0, 16'd1);
    rd("R6 counting after wrap", NS_CNT, 32'h0000_0011);
    rd("R6 status sticky", NS_CTRL, 32'h8600_0042);
    wr(NS_CTRL, 32'h8200_0000);
    chk("R8 irq dropped", {30'd0, ovf_irq}, 32'h0);

    // R7 freeze
    wr(NS_CTRL, 32'h8100_0000);
    wr(NS_CNT, 32'hFFFF_FFFE);
    txn(1'b0, 16'h0, 8'h0, 16'd5);
    rd("R7 overflow value", NS_CNT, 32'd3);
    txn(1'b0, 16'h0, 8'h0, 16'd9);
    rd("R7 frozen", NS_CNT, 32'd3);
    rd("R7 status", NS_CTRL, 32'h8500_0042);
    chk("R8 no irq when disabled", {30'd0, ovf_irq}, 32'h0);
    wr(NS_CTRL, 32'h8100_0000);
    txn(1'b0, 16'h0, 8'h0, 16'd2);
    rd("R7 released", NS_CNT, 32'd5);

    // R11 capture write ignored, R2 secure bank untouched
    wr(NS_CAPT, 32'h0000_ABCD);
    rd("R11 capture read-only", NS_CAPT, 32'd7);
    rd("R2 secure bank untouched", S_CNT, exp_s);

    finish_run();
  end
endmodule